// File: doc/BRIEF.md
# Task-Driven Random Byte Generator

This block produces 8-bit random bytes at a fixed sample period and is controlled through a small 32-bit register window. Software, or another block through two hardware trigger pins, starts and stops generation with one-shot task writes. Each finished sample loads a VALUE register, raises a sticky ready flag and emits a one-cycle pulse on an event output.

A control bit can make the block stop by itself after one sample. An interrupt line is raised while the ready flag is set and the interrupt is enabled. The enable can be written directly, or set and cleared through separate write-one registers. A config bit selects a longer sample period, the one a bias-corrected source would need. The entropy source is modelled by a free-running 16-bit maximal-length LFSR.

Top module: `trng_task_event`

## Requirements
- R1: Writing 1 to offset 0x000, or a one-cycle high on `trig_start_i`, makes the block active and loads the period counter. Writing 1 to offset 0x004, or a one-cycle high on `trig_stop_i`, makes it inactive and cancels the pending sample. A stop trigger wins over a start trigger in the same cycle.
- R2: A sample is taken on the clock edge that falls exactly one period after the trigger edge. On that edge VALUE (offset 0x508, bits 7:0) loads bits 7:0 of the LFSR, the ready flag is set, and `ready_evt_o` is high for that one cycle. The LFSR resets to SEED (default 16'hACE1) and shifts every cycle as s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R3: When SHORTS bit 0 (offset 0x200) is 1, the block goes inactive after a sample. When it is 0, the counter reloads and samples keep coming one period apart.
- R4: `irq_o` is high exactly when the interrupt enable and the ready flag are both 1. It follows every register write and every sample by one edge.
- R5: The ready flag (offset 0x100, bit 0) is cleared only by writing 0 to that offset. Writing any other value leaves it unchanged. A sample in the same cycle keeps it set.
- R6: A write to offset 0x300 loads the enable from bit 0. A write to 0x304 with bit 0 high sets the enable, and a write to 0x308 with bit 0 high clears it. Bit 0 low has no effect in either. Reads of all three return the enable in bit 0.
- R7: The period is FILT_US*CYCLES_PER_US cycles when CONFIG bit 0 (offset 0x504) is 1, and RAW_US*CYCLES_PER_US cycles otherwise. The defaults are 1320 and 334 cycles.
- R8: After reset, VALUE, the active state, the ready flag, SHORTS, the enable and CONFIG all read 0, and no sample is pending.
- R9: Reads of unmapped offsets and of the task offsets return 0. Writes to unmapped offsets change nothing. A task write with a value other than 1 does not trigger.
- R10: A CONFIG change while active takes effect at the next counter load. A start trigger while active reloads the counter, and the sample the earlier start would have produced is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| trig_start_i | input | 1 | Hardware start trigger, active high |
| trig_stop_i | input | 1 | Hardware stop trigger, active high |
| ready_evt_o | output | 1 | One-cycle pulse per sample |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches the control state on every cycle. It checks that stop always leaves the block inactive, that start alone makes it active, and that the shortcut ends activity on a sample. It also checks that an inactive block never pulses, that VALUE changes only together with a pulse, and that the counter never exceeds the longer reload. The bench scenarios cover the timing and data that depend on history: the exact cycle of each pulse for both periods, a period change taking effect mid-run, a restart dropping the earlier sample, the sampled bytes against an independent LFSR model, and the clear and set semantics of the flag and enable registers.

// File: rtl/trng_task_event.sv
module trng_task_event #(
  parameter int          AW            = 12,
  parameter int          CYCLES_PER_US = 2,
  parameter int          RAW_US        = 167,
  parameter int          FILT_US       = 660,
  parameter logic [15:0] SEED          = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          trig_start_i,
  input  logic          trig_stop_i,
  output logic          ready_evt_o,
  output logic          irq_o
);
  localparam int RAW_CYC  = RAW_US * CYCLES_PER_US;
  localparam int FILT_CYC = FILT_US * CYCLES_PER_US;
  localparam int MAX_CYC  = (RAW_CYC > FILT_CYC) ? RAW_CYC : FILT_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] RAW_LOAD  = CW'(RAW_CYC - 1);
  localparam logic [CW-1:0] FILT_LOAD = CW'(FILT_CYC - 1);
  localparam logic [CW-1:0] MAX_LOAD  = CW'(MAX_CYC - 1);

  localparam logic [AW-1:0] OFF_START = AW'(12'h000);
  localparam logic [AW-1:0] OFF_STOP  = AW'(12'h004);
  localparam logic [AW-1:0] OFF_EVT   = AW'(12'h100);
  localparam logic [AW-1:0] OFF_SHORT = AW'(12'h200);
  localparam logic [AW-1:0] OFF_IEN   = AW'(12'h300);
  localparam logic [AW-1:0] OFF_ISET  = AW'(12'h304);
  localparam logic [AW-1:0] OFF_ICLR  = AW'(12'h308);
  localparam logic [AW-1:0] OFF_CFG   = AW'(12'h504);
  localparam logic [AW-1:0] OFF_VAL   = AW'(12'h508);

  logic          active, evt_q, short_q, ien_q, filt_q, pulse_q;
  logic [7:0]    value_q;
  logic [15:0]   lfsr;
  logic [CW-1:0] cnt;

  wire wr_hit_start = bus_wr && bus_addr == OFF_START && bus_wdata == 32'd1;
  wire wr_hit_stop  = bus_wr && bus_addr == OFF_STOP  && bus_wdata == 32'd1;
  wire start_trig   = wr_hit_start || trig_start_i;
  wire stop_trig    = wr_hit_stop  || trig_stop_i;
  wire expire       = active && cnt == '0 && !start_trig && !stop_trig;
  wire [CW-1:0] reload = filt_q ? FILT_LOAD : RAW_LOAD;
  wire lfsr_fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr    <= SEED;
      active  <= 1'b0;
      cnt     <= '0;
      value_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      lfsr    <= {lfsr[14:0], lfsr_fb};
      pulse_q <= 1'b0;
      if (stop_trig) begin
        active <= 1'b0;
      end else if (start_trig) begin
        active <= 1'b1;
        cnt    <= reload;
      end else if (expire) begin
        value_q <= lfsr[7:0];
        pulse_q <= 1'b1;
        if (short_q) active <= 1'b0;
        else         cnt    <= reload;
      end else if (active) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q   <= 1'b0;
      short_q <= 1'b0;
      ien_q   <= 1'b0;
      filt_q  <= 1'b0;
    end else begin
      if (expire)
        evt_q <= 1'b1;
      else if (bus_wr && bus_addr == OFF_EVT && bus_wdata == 32'd0)
        evt_q <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          OFF_SHORT: short_q <= bus_wdata[0];
          OFF_IEN:   ien_q   <= bus_wdata[0];
          OFF_ISET:  if (bus_wdata[0]) ien_q <= 1'b1;
          OFF_ICLR:  if (bus_wdata[0]) ien_q <= 1'b0;
          OFF_CFG:   filt_q  <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_EVT:                    bus_rdata[0]   = evt_q;
      OFF_SHORT:                  bus_rdata[0]   = short_q;
      OFF_IEN, OFF_ISET, OFF_ICLR: bus_rdata[0]  = ien_q;
      OFF_CFG:                    bus_rdata[0]   = filt_q;
      OFF_VAL:                    bus_rdata[7:0] = value_q;
      default: ;
    endcase
  end

  assign ready_evt_o = pulse_q;
  assign irq_o       = ien_q & evt_q;
endmodule

module trng_task_event_chk #(
  parameter int CW = 8,
  parameter logic [CW-1:0] MAX_LOAD = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_trig,
  input logic          stop_trig,
  input logic          active,
  input logic          short_q,
  input logic [CW-1:0] cnt,
  input logic [7:0]    value_q,
  input logic          pulse
);
  // R1
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |=> !active);
  // R1
  start_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_trig && !stop_trig) |=> active);
  // R3
  shortcut_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == '0 && !start_trig && !stop_trig && short_q) |=> (!active && pulse));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start_trig) |=> !pulse);
  // R2
  value_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(value_q) |-> pulse);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MAX_LOAD);
endmodule

bind trng_task_event trng_task_event_chk #(.CW(CW), .MAX_LOAD(MAX_LOAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_trig(start_trig), .stop_trig(stop_trig),
  .active(active), .short_q(short_q), .cnt(cnt), .value_q(value_q), .pulse(pulse_q)
);

// File: tb/sim_trng_task_event.sv
`timescale 1ns/1ps
module sim_trng_task_event;
  localparam int RAW_P  = 334;
  localparam int FILT_P = 1320;
  localparam logic [11:0] A_START = 12'h000, A_STOP = 12'h004, A_EVT = 12'h100,
    A_SHORT = 12'h200, A_IEN = 12'h300, A_ISET = 12'h304, A_ICLR = 12'h308,
    A_CFG = 12'h504, A_VAL = 12'h508;

  logic clk = 0, rst_n = 0, bus_wr = 0, trig_start_i = 0, trig_stop_i = 0;
  logic [11:0] bus_addr = A_VAL;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ready_evt_o, irq_o;

  int checks = 0, failures = 0, cyc = 0, t_edge = 0;
  int exp_q[$];
  logic [15:0] m_s, m_prev;
  logic [31:0] rd;

  always #10 clk = ~clk;

  trng_task_event u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_start_i(trig_start_i),
    .trig_stop_i(trig_stop_i), .ready_evt_o(ready_evt_o), .irq_o(irq_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin m_s <= 16'hACE1; m_prev <= 16'hACE1; end
    else begin m_prev <= m_s; m_s <= {m_s[14:0], m_s[15]^m_s[13]^m_s[12]^m_s[10]}; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = A_VAL; t_edge = cyc;
  endtask

  task automatic rdreg(input logic [11:0] a);
    @(negedge clk); bus_addr = a; #5 rd = bus_rdata;
    @(negedge clk); bus_addr = A_VAL;
  endtask

  task automatic pin(input bit is_start);
    @(negedge clk); if (is_start) trig_start_i = 1; else trig_stop_i = 1;
    @(negedge clk); trig_start_i = 0; trig_stop_i = 0; t_edge = cyc;
  endtask

  task automatic expect_pulse(input int c); exp_q.push_back(c); endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  // Scoreboard monitor: R2 timing and data, R7 period length
  initial forever begin
    @(negedge clk); #5;
    if (rst_n && ready_evt_o === 1'b1) begin
      if (exp_q.size() == 0) check("R2 unexpected pulse at cycle", cyc, 32'hFFFF_FFFF);
      else begin
        int e; e = exp_q.pop_front();
        check("R2/R7 pulse cycle", cyc, e);
        check("R2 sampled byte", bus_rdata, {24'd0, m_prev[7:0]});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R8 reset state
    rdreg(A_VAL);   check("R8 value", rd, 0);
    rdreg(A_EVT);   check("R8 flag", rd, 0);
    rdreg(A_SHORT); check("R8 shorts", rd, 0);
    rdreg(A_IEN);   check("R8 enable", rd, 0);
    rdreg(A_CFG);   check("R8 config", rd, 0);
    check("R8 irq", irq_o, 0);
    idle(RAW_P + 20);
    check("R8 no sample pending", exp_q.size(), 0);

    // R9 ignored task values and unmapped access
    wr(A_START, 32'd2); idle(RAW_P + 20);
    wr(12'h600, 32'hFFFF_FFFF);
    rdreg(12'h600); check("R9 unmapped read", rd, 0);
    rdreg(A_CFG);   check("R9 config untouched", rd, 0);
    rdreg(A_SHORT); check("R9 shorts untouched", rd, 0);
    rdreg(A_START); check("R9 task offset read", rd, 0);

    // R3 shortcut single sample, R7 raw period
    wr(A_SHORT, 32'd1); rdreg(A_SHORT); check("R3 shorts readback", rd, 1);
    wr(A_START, 32'd1); expect_pulse(t_edge + RAW_P);
    idle(2 * RAW_P + 40);
    check("R3 one sample then halt", exp_q.size(), 0);
    rdreg(A_EVT); check("R2 flag set", rd, 1);
    check("R4 irq off while disabled", irq_o, 0);

    // R6 enable registers, R4 irq
    wr(A_ISET, 32'd1);  check("R4 irq on", irq_o, 1);
    wr(A_ICLR, 32'd2);  check("R6 clr bit0 low ignored", irq_o, 1);
    rdreg(A_ICLR);      check("R6 read via clr", rd, 1);
    wr(A_ICLR, 32'd1);  check("R6 clr", irq_o, 0);
    wr(A_IEN, 32'd3);   rdreg(A_ISET); check("R6 direct load", rd, 1);
    wr(A_ISET, 32'd0);  rdreg(A_IEN);  check("R6 set bit0 low ignored", rd, 1);
    wr(A_IEN, 32'd0);   rdreg(A_IEN);  check("R6 direct clear", rd, 0);
    wr(A_IEN, 32'd1);

    // R5 flag clear semantics
    wr(A_EVT, 32'd5); rdreg(A_EVT); check("R5 nonzero write ignored", rd, 1);
    wr(A_EVT, 32'd0); rdreg(A_EVT); check("R5 zero clears", rd, 0);
    check("R4 irq follows flag", irq_o, 0);

    // R1 stop cancels pending sample
    wr(A_START, 32'd1); idle(100); wr(A_STOP, 32'd1); idle(RAW_P + 20);
    check("R1 stop cancels", exp_q.size(), 0);

    // R10 restart while active drops earlier sample
    wr(A_START, 32'd1); idle(200);
    wr(A_START, 32'd1); expect_pulse(t_edge + RAW_P);
    idle(RAW_P + 20);
    check("R10 restart single pulse", exp_q.size(), 0);

    // R1 pins, R3 continuous, R7 filtered period
    wr(A_SHORT, 32'd0); wr(A_CFG, 32'd1);
    pin(1); expect_pulse(t_edge + FILT_P); expect_pulse(t_edge + 2 * FILT_P);
    idle(2 * FILT_P + 10);
    check("R3 continuous two pulses", exp_q.size(), 0);
    check("R4 irq after samples", irq_o, 1);
    wr(A_STOP, 32'd1); idle(FILT_P + 20);
    check("R1 stop halts continuous", exp_q.size(), 0);

    // R10 config change mid-run
    wr(A_CFG, 32'd0);
    wr(A_START, 32'd1); expect_pulse(t_edge + RAW_P); expect_pulse(t_edge + RAW_P + FILT_P);
    idle(100); wr(A_CFG, 32'd1);
    idle(RAW_P + FILT_P);
    check("R10 config at next load", exp_q.size(), 0);
    pin(0); idle(FILT_P + 20);
    check("R1 stop pin", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule